// File: doc/BRIEF.md
# Pattern-Triggered Ping-Pong Packet Capture

This block is a receive DMA channel for one logical channel of a frame-synchronous byte stream. It scans the incoming bytes for a programmable start byte. When it finds one, it stores the packet that follows through a plain memory write port made of a strobe, an address and a data byte. Packet boundaries are carried in the stream itself. In length mode, a byte inside the packet gives the packet length. In delimiter mode, a second programmable byte closes the packet.

Successive packets alternate between two half-buffers: one at the base address and one at the base address plus the half-buffer size. Software does not re-arm the channel between packets. The channel keeps capturing until it is disabled. Clearing the enable input abandons any packet in progress but keeps the half-buffer selection.

The mode, the patterns, the mask, the length position, the base address and the half-buffer size are expected to stay stable while the channel is enabled. The half-buffer size must be at least 1.

Top module: `pp_capture_dma`

## Requirements
- R1: While reset is asserted, and on every cycle after a clock edge at which `en` was low, `wr_en`, `done` and `hdone` are 0. Bytes presented while `en` is low are ignored.
- R2: A received byte matches a pattern as follows.
  - With `exact_match`=1, all 8 bits must be equal to the pattern.
  - With `exact_match`=0, only the bit positions where `pat_mask` is 1 are compared.
  - The start and stop patterns are both compared this way.
- R3: The start byte itself is not stored. Each later byte with `rx_valid`=1 is written one cycle after it is sampled: `wr_en` is 1, `wr_data` is the byte, and `wr_addr` is the half-buffer origin plus the byte index, where index 0 is the first byte after the start byte. Cycles with `rx_valid`=0 are skipped.
- R4: With `mode`=0 (length mode), the byte at index `count_pos` is the length L. Exactly L bytes, counting from index 0, are written. `done` is a one-cycle pulse that comes together with the last write.
- R5: In length mode, an L of 0 or an L greater than `half_size` is replaced by `half_size`. If L ≤ `count_pos`+1, the capture ends with the length byte itself.
- R6: With `mode`=1 (delimiter mode), after `en` rises the channel ignores start bytes until a cycle with `frame_start`=1. The byte sampled in that same cycle is already examined for the start pattern.
- R7: In delimiter mode, a byte that matches `stop_pat` ends the capture. That byte is not stored, and `hdone` pulses for one cycle, one cycle after the stop byte is sampled, with no write in that cycle.
- R8: In delimiter mode, bytes after the first `half_size` bytes of a packet are not written, and the capture still waits for the stop byte.
- R9: The first, third and every later odd-numbered completed packet is written from `base_addr`. Even-numbered packets are written from `base_addr`+`half_size`. The selection toggles on each `done` or `hdone`.
- R10: Clearing `en` during a capture stops the writes at once. It raises no completion pulse and leaves the half-buffer selection unchanged. After `en` is set again, the channel is searching for a start byte, and in delimiter mode it first waits for `frame_start` again.
- R11: After a packet completes, the channel returns to searching for the start byte, without waiting for a frame start. Bytes between packets are not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Channel enable |
| mode | input | 1 | 0 = length mode, 1 = delimiter mode |
| frame_start | input | 1 | Marks the first byte slot of a frame |
| rx_valid | input | 1 | A byte of the logical channel is present |
| rx_byte | input | 8 | Received byte |
| start_pat | input | 8 | Start pattern |
| stop_pat | input | 8 | Stop pattern (delimiter mode) |
| pat_mask | input | 8 | Compare mask for masked matching |
| exact_match | input | 1 | 1 = compare all bits, 0 = masked compare |
| count_pos | input | CPW | Index of the length byte in the packet |
| base_addr | input | AW | Origin of the first half-buffer |
| half_size | input | AW | Half-buffer size in bytes, also the second origin's offset |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | AW | Memory write address |
| wr_data | output | 8 | Memory write data |
| done | output | 1 | Length-mode packet complete pulse |
| hdone | output | 1 | Delimiter-mode packet complete pulse |

## Verification
The embedded properties check on every cycle that:
- Outputs fall quiet after a disabled cycle.
- `done` only comes together with a write, and `hdone` never does.
- Each completion flips the half-buffer selection.
- Every write lands inside the two half-buffers.
- A delimiter-mode channel cannot start capturing before a frame start.

Only the bench scenarios can show the data-dependent results, namely:
- The exact byte and address sequence.
- Length extraction and its clamping.
- Masked versus exact matching.
- Dropping of overflow bytes.
- The half-buffer selection being kept across a mid-packet disable.

// File: rtl/pp_capture_dma.sv
module pp_capture_dma #(
  parameter int AW  = 16,
  parameter int CPW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           mode,
  input  logic           frame_start,
  input  logic           rx_valid,
  input  logic [7:0]     rx_byte,
  input  logic [7:0]     start_pat,
  input  logic [7:0]     stop_pat,
  input  logic [7:0]     pat_mask,
  input  logic           exact_match,
  input  logic [CPW-1:0] count_pos,
  input  logic [AW-1:0]  base_addr,
  input  logic [AW-1:0]  half_size,
  output logic           wr_en,
  output logic [AW-1:0]  wr_addr,
  output logic [7:0]     wr_data,
  output logic           done,
  output logic           hdone
);

  typedef enum logic [1:0] {S_OFF, S_WAITF, S_HUNT, S_CAP} st_t;

  st_t           state;
  logic [AW-1:0] idx;
  logic [AW-1:0] lim;
  logic          len_known;
  logic          bank;

  logic [7:0]    cmp_mask;
  logic          hit_start, hit_stop, hunting;
  logic [AW-1:0] byte_len, clamp_len, cur_lim, origin;
  logic          at_pos, last_var;

  assign cmp_mask  = exact_match ? 8'hFF : pat_mask;
  assign hit_start = ((rx_byte ^ start_pat) & cmp_mask) == 8'h00;
  assign hit_stop  = ((rx_byte ^ stop_pat)  & cmp_mask) == 8'h00;
  assign hunting   = (state == S_HUNT) || (state == S_WAITF && frame_start);

  assign byte_len  = AW'(rx_byte);
  assign clamp_len = (rx_byte == 8'h00 || byte_len > half_size) ? half_size : byte_len;
  assign at_pos    = idx == AW'(count_pos);
  assign cur_lim   = len_known ? lim : (at_pos ? clamp_len : half_size);
  assign last_var  = ({1'b0, idx} + 1'b1) >= {1'b0, cur_lim};
  assign origin    = base_addr + (bank ? half_size : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_OFF;
      idx       <= '0;
      lim       <= '0;
      len_known <= 1'b0;
      bank      <= 1'b0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      done      <= 1'b0;
      hdone     <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      hdone <= 1'b0;
      if (!en) begin
        state     <= S_OFF;
        idx       <= '0;
        len_known <= 1'b0;
      end else begin
        case (state)
          S_OFF: state <= mode ? S_WAITF : S_HUNT;
          S_WAITF, S_HUNT: begin
            if (hunting && rx_valid && hit_start) begin
              state     <= S_CAP;
              idx       <= '0;
              len_known <= 1'b0;
            end else if (state == S_WAITF && frame_start) begin
              state <= S_HUNT;
            end
          end
          S_CAP: begin
            if (rx_valid) begin
              if (!mode) begin
                wr_en   <= 1'b1;
                wr_addr <= origin + idx;
                wr_data <= rx_byte;
                if (!len_known && at_pos) begin
                  len_known <= 1'b1;
                  lim       <= clamp_len;
                end
                if (last_var) begin
                  done  <= 1'b1;
                  bank  <= ~bank;
                  state <= S_HUNT;
                end else begin
                  idx <= idx + 1'b1;
                end
              end else if (hit_stop) begin
                hdone <= 1'b1;
                bank  <= ~bank;
                state <= S_HUNT;
              end else if (idx < half_size) begin
                wr_en   <= 1'b1;
                wr_addr <= origin + idx;
                wr_data <= rx_byte;
                idx     <= idx + 1'b1;
              end
            end
          end
          default: state <= S_OFF;
        endcase
      end
    end
  end

  // R1: a disabled cycle silences every output on the following cycle
  a_r1_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!wr_en && !done && !hdone));

  // R4: the length-mode completion pulse rides on the final write
  a_r4_done_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> wr_en);

  // R7: the stop byte is never stored
  a_r7_hdone_alone: assert property (@(posedge clk) disable iff (!rst_n)
    hdone |-> !wr_en);

  // R9: every completion swaps the half-buffer
  a_r9_bank_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (done || hdone) |-> bank != $past(bank));

  // R9: writes stay inside the two half-buffers
  a_r9_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> {1'b0, AW'(wr_addr - base_addr)} < ({1'b0, half_size} << 1));

  // R6: no capture may begin before a frame start in delimiter mode
  a_r6_frame_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAITF && !frame_start) |=> state != S_CAP);

endmodule

// File: tb/test_pp_capture_dma.sv
module test_pp_capture_dma;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 16;
  localparam int CPW = 4;
  localparam logic [AW-1:0] BASE = 16'h0100;
  localparam logic [AW-1:0] HALF = 16'd8;

  logic clk = 1'b0;
  logic rst_n, en, mode, frame_start, rx_valid, exact_match;
  logic [7:0] rx_byte, start_pat, stop_pat, pat_mask;
  logic [CPW-1:0] count_pos;
  logic [AW-1:0] base_addr, half_size;
  logic wr_en, done, hdone;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  pp_capture_dma #(.AW(AW), .CPW(CPW)) i_pp_capture_dma (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .frame_start(frame_start),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .start_pat(start_pat), .stop_pat(stop_pat),
    .pat_mask(pat_mask), .exact_match(exact_match), .count_pos(count_pos),
    .base_addr(base_addr), .half_size(half_size), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done), .hdone(hdone));

  typedef struct packed {
    logic          is_h;
    logic [AW-1:0] a;
    logic [7:0]    d;
    logic          f;
    logic [7:0]    req;
  } item_t;

  item_t exp_q[$];
  int compared = 0;
  int mismatched = 0;
  bit eb = 1'b0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // monitor: compare each produced write or hdone against the queue head
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (wr_en) begin
        if (exp_q.size() == 0) begin
          check(0, "R11", "unexpected write addr", 32'(wr_addr), 32'hFFFF_FFFF);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          check(!e.is_h, $sformatf("R%0d", e.req), "write where hdone due", 1, 0);
          check(wr_addr == e.a, $sformatf("R%0d", e.req), "wr_addr", 32'(wr_addr), 32'(e.a));
          check(wr_data == e.d, $sformatf("R%0d", e.req), "wr_data", 32'(wr_data), 32'(e.d));
          check(done == e.f, "R4", "done with write", 32'(done), 32'(e.f));
        end
      end else if (done) begin
        check(0, "R4", "done without write", 1, 0);
      end
      if (hdone) begin
        if (exp_q.size() == 0 || !exp_q[0].is_h) begin
          check(0, "R7", "unexpected hdone", 1, 0);
        end else begin
          void'(exp_q.pop_front());
          check(1, "R7", "hdone", 1, 1);
        end
      end
    end
  end

  task automatic send(input logic [7:0] b, input bit fs = 1'b0);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b; frame_start = fs;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      rx_valid = 1'b0; frame_start = 1'b0;
    end
  endtask

  function automatic logic [AW-1:0] org();
    return BASE + (eb ? HALF : '0);
  endfunction

  // length mode packet: bytes after start; expectation from R4/R5 rules
  task automatic var_pkt(input logic [7:0] sb, input logic [7:0] q[$], input int r);
    int l, n;
    l = int'(q[count_pos]);
    if (l == 0 || l > int'(HALF)) l = int'(HALF);
    n = (l <= int'(count_pos) + 1) ? int'(count_pos) + 1 : l;
    for (int i = 0; i < n; i++)
      exp_q.push_back('{1'b0, org() + AW'(i), q[i], (i == n - 1), 8'(r)});
    eb = ~eb;
    send(sb);
    foreach (q[i]) send(q[i]);
    idle(3);
  endtask

  // delimiter mode packet: payload then stop byte (R7, R8)
  task automatic ss_pkt(input logic [7:0] q[$], input bit fs, input int r);
    for (int i = 0; i < q.size() && i < int'(HALF); i++)
      exp_q.push_back('{1'b0, org() + AW'(i), q[i], 1'b0, 8'(r)});
    exp_q.push_back('{1'b1, '0, 8'h00, 1'b0, 8'd7});
    eb = ~eb;
    send(8'hA5, fs);
    foreach (q[i]) send(q[i]);
    send(8'h5A);
    idle(3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "WDOG", "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; mode = 1'b0; frame_start = 1'b0; rx_valid = 1'b0;
    rx_byte = 8'h00; start_pat = 8'hA5; stop_pat = 8'h5A; pat_mask = 8'hF0;
    exact_match = 1'b1; count_pos = CPW'(1); base_addr = BASE; half_size = HALF;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!wr_en && !done && !hdone, "R1", "outputs in reset",
          {29'd0, wr_en, done, hdone}, 0);
    rst_n = 1'b1;
    // R1: bytes while disabled are ignored (monitor flags any write)
    send(8'hA5); send(8'h01); send(8'h02); idle(3);
    en = 1'b1; idle(2);
    // R11: junk before start is not written
    send(8'h11); send(8'h22); idle(1);
    // R3 R4: length 4 at index 1, bank 0
    var_pkt(8'hA5, '{8'h30, 8'h04, 8'h32, 8'h33, 8'h44}, 4);
    // R5: length 0 clamps to half size, bank 1 (R9)
    var_pkt(8'hA5, '{8'h01, 8'h00, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09}, 9);
    // R5: length 200 clamps to half size, bank 0
    var_pkt(8'hA5, '{8'h21, 8'hC8, 8'h23, 8'h24, 8'h25, 8'h26, 8'h27, 8'h28}, 5);
    // R5: length 1 ends at the length byte itself
    var_pkt(8'hA5, '{8'h41, 8'h01, 8'h43}, 5);
    // R2: masked compare, A3 matches A5 under mask F0
    exact_match = 1'b0;
    var_pkt(8'hA3, '{8'h12, 8'h03, 8'h14}, 2);
    exact_match = 1'b1;
    // R2: exact compare rejects A3 (no writes expected)
    send(8'hA3); send(8'h01); send(8'h02); idle(3);
    // R10: disable mid capture, writes stop, bank kept
    exp_q.push_back('{1'b0, org(), 8'h01, 1'b0, 8'd10});
    exp_q.push_back('{1'b0, org() + 1, 8'h05, 1'b0, 8'd10});
    send(8'hA5); send(8'h01); send(8'h05); idle(1);
    en = 1'b0; send(8'h02); send(8'h03); idle(1);
    en = 1'b1; idle(2);
    send(8'h04); idle(2);
    var_pkt(8'hA5, '{8'h31, 8'h03, 8'h33}, 10);
    // R6: delimiter mode waits for frame start
    en = 1'b0; mode = 1'b1; idle(2); en = 1'b1; idle(2);
    send(8'hA5); send(8'h01); send(8'h5A); idle(3);
    check(exp_q.size() == 0, "R6", "no activity before frame start", exp_q.size(), 0);
    ss_pkt('{8'h10, 8'h11, 8'h12}, 1'b1, 6);
    // R8: overflow bytes dropped until stop
    ss_pkt('{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A}, 1'b0, 8);
    // R11: next packet without frame start
    ss_pkt('{8'h20}, 1'b0, 11);
    // R10: disabled in delimiter mode requires a frame start again
    en = 1'b0; idle(2); en = 1'b1; idle(2);
    send(8'hA5); send(8'h01); send(8'h5A); idle(3);
    ss_pkt('{8'h22, 8'h23}, 1'b1, 10);
    idle(4);
    check(exp_q.size() == 0, "R9", "all expected items produced", exp_q.size(), 0);
    finish_up();
  end
endmodule